// File: doc/BRIEF.md
# Countdown Physical Register Scoreboard

This block keeps, for every physical register, a small signed counter that says when the register's value can be used. The counter has three meanings. A negative value means the producing micro-op has been allocated but has not issued yet. A positive value is the number of cycles left before the result exists. Zero means the value is available.

The rename stage writes -1 into each destination it allocates. The issue stage writes the producer's execution latency into each destination: 3 for a load and 1 for any other micro-op. At every clock edge, each positive counter that receives no explicit write that cycle steps down by one.

The scheduler asks, through a set of read ports, whether each source of the micro-ops it is considering is ready. A read returns ready exactly when the counter for that register is zero. Reads report the stored state at the start of the cycle.

Top module: `phys_reg_scoreboard`

## Requirements
- R1: After reset every counter is zero, so every register reads as ready.
- R2: Each read port j (micro-op slot s, source k, j = s*SRC_PER+k, register index in `rd_preg[j*PREG_W +: PREG_W]`) independently reports `rd_ready[j]`=1 exactly when the addressed counter is zero.
- R3: An allocation write sets the destination counter to -1. The register then reads not ready and stays not ready until an issue write reaches it.
- R4: An issue write sets the counter to 3 when `issue_is_load` of that slot is 1, and to 1 otherwise. A register issued on clock edge e reads ready from edge e+3 (load) or edge e+1 (other). The counter never leaves the range -1..3.
- R5: On each edge with no write to it, a positive counter decreases by one, while a zero or negative counter keeps its value.
- R6: An explicit write to a counter takes effect in place of that counter's decrement in the same cycle.
- R7: When several writes hit one counter in a cycle, an allocation write beats an issue write, and among writes of the same kind the highest flat destination index wins.
- R8: Destination d of slot s uses flat index i = s*DST_PER+d, with register index in `*_dst[i*PREG_W +: PREG_W]`. A destination writes only when both its slot valid bit and its own destination valid bit are 1.
- R9: A write becomes visible to the read ports only after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | SLOTS | Allocation slot valid |
| alloc_dst_vld | input | SLOTS*DST_PER | Allocation destination valid, flat index s*DST_PER+d |
| alloc_dst | input | SLOTS*DST_PER*PREG_W | Allocation destination register numbers |
| issue_valid | input | SLOTS | Issue slot valid |
| issue_is_load | input | SLOTS | Issued micro-op is a load (latency 3) |
| issue_dst_vld | input | SLOTS*DST_PER | Issue destination valid |
| issue_dst | input | SLOTS*DST_PER*PREG_W | Issue destination register numbers |
| rd_preg | input | SLOTS*SRC_PER*PREG_W | Source register numbers to query |
| rd_ready | output | SLOTS*SRC_PER | Readiness of each queried source |

## Verification
The per-entry assertions check on every cycle the counter behaviour for each entry. They cover the value held after reset, the hold of pending and zero counters, the one-step countdown of positive counters, the override of the decrement by an explicit write, and the legal value range.

Other behaviours can only be shown by the bench's directed scenarios, observed at the read ports. These are:
- how ports are gated by slot and destination valid bits;
- the exact ready edge for loads and other micro-ops;
- which writer wins when several hit one register;
- the one-cycle gap before a write becomes visible to reads.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  localparam int CNT_W = 3;
  typedef logic signed [CNT_W-1:0] sb_cnt_t;

  localparam sb_cnt_t CNT_READY   = 3'sd0;
  localparam sb_cnt_t CNT_PENDING = -3'sd1;
  localparam sb_cnt_t LAT_LOAD    = 3'sd3;
  localparam sb_cnt_t LAT_ALU     = 3'sd1;

  // Latency loaded into a destination when its producer issues.
  function automatic sb_cnt_t latency_of(input logic is_load);
    return is_load ? LAT_LOAD : LAT_ALU;
  endfunction

  // Per-cycle step of a counter that receives no explicit write.
  function automatic sb_cnt_t count_step(input sb_cnt_t c);
    return (c > CNT_READY) ? sb_cnt_t'(c - 3'sd1) : c;
  endfunction

  function automatic logic is_ready(input sb_cnt_t c);
    return c == CNT_READY;
  endfunction
endpackage

// File: rtl/sb_write_decode.sv
`timescale 1ns/1ps
// Collects every write port aimed at one entry and resolves priority:
// issue writes first, allocation writes after (so they win), and a later
// flat index overrides an earlier one within each kind.
module sb_write_decode
  import sb_pkg::*;
#(
  parameter int SLOTS   = 2,
  parameter int DST_PER = 2,
  parameter int PREG_W  = 6,
  parameter int ENTRY   = 0
) (
  input  logic [SLOTS-1:0]                alloc_valid,
  input  logic [SLOTS*DST_PER-1:0]        alloc_dst_vld,
  input  logic [SLOTS*DST_PER*PREG_W-1:0] alloc_dst,
  input  logic [SLOTS-1:0]                issue_valid,
  input  logic [SLOTS-1:0]                issue_is_load,
  input  logic [SLOTS*DST_PER-1:0]        issue_dst_vld,
  input  logic [SLOTS*DST_PER*PREG_W-1:0] issue_dst,
  output logic                            wr_hit,
  output sb_cnt_t                         wr_val
);
  localparam int NDST = SLOTS * DST_PER;
  localparam logic [PREG_W-1:0] MY_ID = PREG_W'(ENTRY);

  always_comb begin
    wr_hit = 1'b0;
    wr_val = CNT_READY;
    for (int i = 0; i < NDST; i++) begin
      if (issue_valid[i / DST_PER] && issue_dst_vld[i] &&
          issue_dst[i*PREG_W +: PREG_W] == MY_ID) begin
        wr_hit = 1'b1;
        wr_val = latency_of(issue_is_load[i / DST_PER]);
      end
    end
    for (int i = 0; i < NDST; i++) begin
      if (alloc_valid[i / DST_PER] && alloc_dst_vld[i] &&
          alloc_dst[i*PREG_W +: PREG_W] == MY_ID) begin
        wr_hit = 1'b1;
        wr_val = CNT_PENDING;
      end
    end
  end
endmodule

// File: rtl/sb_entry.sv
`timescale 1ns/1ps
// One countdown counter with its own per-cycle checks.
module sb_entry
  import sb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_hit,
  input  sb_cnt_t wr_val,
  output sb_cnt_t cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= CNT_READY;
    else if (wr_hit) cnt <= wr_val;
    else             cnt <= count_step(cnt);
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cnt == CNT_READY); // R1
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> cnt == $past(wr_val)); // R6
  AST_PENDING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && cnt < CNT_READY) |=> cnt == $past(cnt)); // R5
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && cnt == CNT_READY) |=> cnt == CNT_READY); // R5
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && cnt > CNT_READY) |=> cnt == $past(cnt) - 3'sd1); // R5
  AST_LEGAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= CNT_PENDING) && (cnt <= LAT_LOAD)); // R4
endmodule

// File: rtl/sb_read_port.sv
`timescale 1ns/1ps
// One source query: selects the addressed counter and reports readiness.
module sb_read_port
  import sb_pkg::*;
#(
  parameter int NUM_PREGS = 64,
  parameter int PREG_W    = 6
) (
  input  logic [NUM_PREGS*CNT_W-1:0] cnt_bus,
  input  logic [PREG_W-1:0]          preg,
  output logic                       ready
);
  always_comb begin
    ready = 1'b0;
    for (int e = 0; e < NUM_PREGS; e++) begin
      if (preg == PREG_W'(e))
        ready = is_ready(sb_cnt_t'(cnt_bus[e*CNT_W +: CNT_W]));
    end
  end
endmodule

// File: rtl/phys_reg_scoreboard.sv
`timescale 1ns/1ps
module phys_reg_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_PREGS = 64,
  parameter int SLOTS     = 2,
  parameter int DST_PER   = 2,
  parameter int SRC_PER   = 3,
  parameter int PREG_W    = $clog2(NUM_PREGS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [SLOTS-1:0]                alloc_valid,
  input  logic [SLOTS*DST_PER-1:0]        alloc_dst_vld,
  input  logic [SLOTS*DST_PER*PREG_W-1:0] alloc_dst,
  input  logic [SLOTS-1:0]                issue_valid,
  input  logic [SLOTS-1:0]                issue_is_load,
  input  logic [SLOTS*DST_PER-1:0]        issue_dst_vld,
  input  logic [SLOTS*DST_PER*PREG_W-1:0] issue_dst,
  input  logic [SLOTS*SRC_PER*PREG_W-1:0] rd_preg,
  output logic [SLOTS*SRC_PER-1:0]        rd_ready
);
  localparam int NRD = SLOTS * SRC_PER;

  logic [NUM_PREGS*CNT_W-1:0] cnt_bus;
  logic [NUM_PREGS-1:0]       entry_wr_hit;

  for (genvar e = 0; e < NUM_PREGS; e++) begin : g_entry
    sb_cnt_t wr_val;
    sb_cnt_t cnt;

    sb_write_decode #(
      .SLOTS(SLOTS), .DST_PER(DST_PER), .PREG_W(PREG_W), .ENTRY(e)
    ) u_dec (
      .alloc_valid(alloc_valid), .alloc_dst_vld(alloc_dst_vld), .alloc_dst(alloc_dst),
      .issue_valid(issue_valid), .issue_is_load(issue_is_load),
      .issue_dst_vld(issue_dst_vld), .issue_dst(issue_dst),
      .wr_hit(entry_wr_hit[e]), .wr_val(wr_val)
    );

    sb_entry u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_hit(entry_wr_hit[e]), .wr_val(wr_val), .cnt(cnt)
    );

    assign cnt_bus[e*CNT_W +: CNT_W] = cnt;
  end

  for (genvar j = 0; j < NRD; j++) begin : g_rd
    sb_read_port #(.NUM_PREGS(NUM_PREGS), .PREG_W(PREG_W)) u_rd (
      .cnt_bus(cnt_bus), .preg(rd_preg[j*PREG_W +: PREG_W]), .ready(rd_ready[j])
    );
  end
endmodule

// File: tb/tb_phys_reg_scoreboard.sv
`timescale 1ns/1ps
module tb_phys_reg_scoreboard;
  localparam int NP = 64, S = 2, D = 2, R = 3, PW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [S-1:0]      alloc_valid, issue_valid, issue_is_load;
  logic [S*D-1:0]    alloc_dst_vld, issue_dst_vld;
  logic [S*D*PW-1:0] alloc_dst, issue_dst;
  logic [S*R*PW-1:0] rd_preg;
  logic [S*R-1:0]    rd_ready;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk; // 125 MHz

  phys_reg_scoreboard #(.NUM_PREGS(NP), .SLOTS(S), .DST_PER(D), .SRC_PER(R)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_dst_vld(alloc_dst_vld), .alloc_dst(alloc_dst),
    .issue_valid(issue_valid), .issue_is_load(issue_is_load),
    .issue_dst_vld(issue_dst_vld), .issue_dst(issue_dst),
    .rd_preg(rd_preg), .rd_ready(rd_ready)
  );

  task automatic clear_in();
    alloc_valid = '0; alloc_dst_vld = '0; alloc_dst = '0;
    issue_valid = '0; issue_is_load = '0; issue_dst_vld = '0; issue_dst = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    clear_in();
  endtask

  task automatic put_alloc(input int s, input int d, input int p);
    alloc_valid[s] = 1'b1;
    alloc_dst_vld[s*D+d] = 1'b1;
    alloc_dst[(s*D+d)*PW +: PW] = PW'(p);
  endtask

  task automatic put_issue(input int s, input int d, input int p, input logic ld);
    issue_valid[s] = 1'b1;
    issue_is_load[s] = ld;
    issue_dst_vld[s*D+d] = 1'b1;
    issue_dst[(s*D+d)*PW +: PW] = PW'(p);
  endtask

  task automatic check(input int port, input int p, input logic exp, input string tag);
    rd_preg[port*PW +: PW] = PW'(p);
    #0.1;
    checks++;
    if (rd_ready[port] !== exp) begin
      fails++;
      $display("FAIL %s: p%0d port %0d ready=%0b expected %0b", tag, p, port, rd_ready[port], exp);
    end
  endtask

  // R1, R2: every register ready after reset, on every read port
  task automatic t_reset();
    check(0, 0, 1'b1, "R1");
    check(1, 63, 1'b1, "R1");
    check(2, 17, 1'b1, "R2");
    check(3, 5, 1'b1, "R2");
    check(4, 40, 1'b1, "R2");
    check(5, 31, 1'b1, "R2");
  endtask

  // R3, R5, R9: allocation makes register pending and it stays pending
  task automatic t_alloc_hold();
    put_alloc(0, 0, 5);
    check(0, 5, 1'b1, "R9 before edge");
    step();
    check(0, 5, 1'b0, "R3");
    for (int i = 0; i < 6; i++) begin
      step();
      check(i % (S*R), 5, 1'b0, "R5 pending hold");
    end
  endtask

  // R4, R5: non-load issue ready one edge later and stays ready
  task automatic t_issue_alu();
    put_issue(1, 1, 5, 1'b0);
    check(2, 5, 1'b0, "R9 issue before edge");
    step();
    check(2, 5, 1'b0, "R4 alu +0");
    step();
    check(3, 5, 1'b1, "R4 alu +1");
    for (int i = 0; i < 3; i++) begin
      step();
      check(4, 5, 1'b1, "R5 zero hold");
    end
  endtask

  // R4: load ready three edges after issue
  task automatic t_issue_load();
    put_alloc(1, 0, 9);
    step();
    put_issue(0, 1, 9, 1'b1);
    step();
    check(0, 9, 1'b0, "R4 load cnt3");
    step();
    check(1, 9, 1'b0, "R4 load cnt2");
    step();
    check(2, 9, 1'b0, "R4 load cnt1");
    step();
    check(3, 9, 1'b1, "R4 load ready");
  endtask

  // R6: explicit writes replace the decrement
  task automatic t_write_wins();
    put_alloc(0, 0, 20);
    step();
    put_issue(0, 0, 20, 1'b1);
    step();
    put_issue(1, 0, 20, 1'b0);
    step();
    check(0, 20, 1'b0, "R6 reload to 1");
    step();
    check(0, 20, 1'b1, "R6 reload ready");
    put_issue(0, 0, 21, 1'b1);
    step();
    put_alloc(1, 1, 21);
    step();
    for (int i = 0; i < 5; i++) begin
      step();
      check(5, 21, 1'b0, "R6 alloc over countdown");
    end
  endtask

  // R7: allocation beats issue; higher index wins within a kind
  task automatic t_priority();
    put_alloc(0, 1, 30);
    put_issue(1, 0, 30, 1'b0);
    step();
    step();
    check(1, 30, 1'b0, "R7 alloc over issue");
    step();
    check(1, 30, 1'b0, "R7 alloc over issue");
    put_issue(0, 0, 31, 1'b1);
    put_issue(1, 1, 31, 1'b0);
    step();
    check(2, 31, 1'b0, "R7 same-kind +0");
    step();
    check(2, 31, 1'b1, "R7 higher index wins");
  endtask

  // R8: slot and destination valid bits gate writes
  task automatic t_gating();
    put_alloc(0, 0, 40);
    alloc_dst_vld[0] = 1'b0;
    step();
    check(0, 40, 1'b1, "R8 dst_vld gate");
    put_alloc(1, 1, 41);
    alloc_valid[1] = 1'b0;
    step();
    check(1, 41, 1'b1, "R8 slot valid gate");
    put_alloc(0, 1, 42);
    step();
    put_issue(1, 0, 42, 1'b0);
    issue_valid[1] = 1'b0;
    step();
    step();
    check(2, 42, 1'b0, "R8 issue slot gate");
  endtask

  // R2, R8: four destinations in one cycle, read on separate ports
  task automatic t_multi();
    put_alloc(0, 0, 50); put_alloc(0, 1, 51);
    put_alloc(1, 0, 52); put_alloc(1, 1, 53);
    step();
    check(0, 50, 1'b0, "R2 multi");
    check(1, 51, 1'b0, "R2 multi");
    check(3, 52, 1'b0, "R2 multi");
    check(5, 53, 1'b0, "R2 multi");
    put_issue(0, 0, 50, 1'b0); put_issue(0, 1, 51, 1'b0);
    put_issue(1, 0, 52, 1'b1); put_issue(1, 1, 53, 1'b1);
    step();
    step();
    check(0, 50, 1'b1, "R8 slot0 alu");
    check(4, 51, 1'b1, "R8 slot0 alu");
    check(3, 52, 1'b0, "R8 slot1 load");
    check(5, 53, 1'b0, "R8 slot1 load");
    step();
    step();
    check(3, 52, 1'b1, "R8 slot1 load ready");
  endtask

  initial begin
    rst_n = 1'b0;
    rd_preg = '0;
    clear_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_alloc_hold();
    t_issue_alu();
    t_issue_load();
    t_write_wins();
    t_priority();
    t_gating();
    t_multi();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule